// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs clause 22 management transactions on a two-wire MDIO bus towards an external PHY. Software writes a 32-bit command word into the frame register. If the word is a well-formed read or write and a nonzero clock divider has been programmed, the block generates the management clock (MDC) from the system clock and shifts a complete 64-bit management frame onto MDIO. The frame is a 32-bit preamble of ones, the start pattern, the opcode, the PHY and register addresses, the turnaround and 16 data bits, sent MSB first.

During a read the block releases the data line for the turnaround and the data phase. It samples the PHY's bits on the rising MDC edge and, when the frame ends, places the 16 received bits into the low half of the frame register. Every finished transaction sets a sticky completion event. Writing a one clears the event, and an enable input gates it onto the interrupt line.

The command and divider inputs are plain register write strobes with no back-pressure. A frame write that arrives while a transaction is running is dropped, and software is expected to wait for the busy flag or the event before it writes again.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: A frame write while idle always stores the word in the frame register. A transaction starts only if bits 30 and 17 are both 1 and exactly one of bit 29 (read) and bit 28 (write) is 1. The PHY address sits in bits 27:23, the register address in bits 22:18 and the write data in bits 15:0.
- R2: While the divider value is zero, no transaction starts and MDC does not toggle.
- R3: The divider value is bits 6:1 of the speed write data. A running MDC has a period of 2*(value+1) system clock cycles. MDC rests low when idle.
- R4: The bus carries, in order: 32 ones, 0 then 1, the opcode (1 0 for read, 0 1 for write), the PHY address, the register address, the turnaround (1 0 on a write), and then 16 data bits. Every field is sent MSB first.
- R5: The MDIO output changes only on a falling MDC edge or when a transaction starts. The enable is high through the whole of a write frame. On a read it is low from the turnaround (frame bit 46) to the end. It is low while idle, with the output at 1.
- R6: On a read, the data bits sampled at the rising MDC edges of frame bits 48 to 63 replace frame register bits 15:0 at completion. Bits 31:16 keep the command.
- R7: Each completed frame sets the event output. A clear strobe resets it, but a completion in the same cycle wins. The interrupt output is the event ANDed with the interrupt enable.
- R8: A frame write while busy is ignored: the frame register and the running frame are unchanged, and no extra transaction follows.
- R9: Busy rises the cycle after an accepted write and falls on the 64th falling MDC edge. After reset, busy, MDC, the event and the frame register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_wr_i | input | 1 | Frame register write strobe |
| frame_wdata_i | input | 32 | Command word |
| frame_rdata_o | output | 32 | Frame register contents |
| div_wr_i | input | 1 | Speed register write strobe |
| div_wdata_i | input | 32 | Speed word, divider in bits 6:1 |
| evt_w1c_i | input | 1 | Write-one-to-clear strobe for the event |
| irq_en_i | input | 1 | Interrupt enable |
| event_o | output | 1 | Sticky completion event |
| irq_o | output | 1 | Gated interrupt |
| busy_o | output | 1 | Transaction in progress |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
Some properties are checked on every cycle. MDC rests low and the driver is released while idle. The data line moves only at a falling MDC edge. A zero divider never lets busy rise. The frame register holds still for the whole transaction. Every end of busy leaves the event set.

Other behaviour needs whole transactions from the bench. The bench checks the bit-exact frame order and the enable pattern of reads against writes. It checks the MDC period at several divider values and the read data captured from a PHY model. It also checks that malformed words and writes made while busy produce no frame at all.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_VLD_HI = 30;
  localparam int CMD_VLD_LO = 17;
  localparam int CMD_RD     = 29;
  localparam int CMD_WR     = 28;
  localparam int CMD_PHY_LSB = 23;
  localparam int CMD_REG_LSB = 18;
  localparam int DIV_LSB    = 1;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  localparam logic [1:0] SOF_PATTERN = 2'b01;
  localparam logic [1:0] TA_DRIVEN   = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick   = run_i && (cnt_q >= div_i);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
  parameter int SEQ_LEN = 64,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               is_read_i,
  input  logic [SEQ_LEN-1:0] word_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               mdio_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  localparam int IDX_W   = $clog2(SEQ_LEN);
  localparam int DATA_AT = SEQ_LEN - DATA_W;
  localparam int TA_AT   = DATA_AT - 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

  logic [SEQ_LEN-1:0] shift_q;
  logic [IDX_W-1:0]   idx_q;
  logic               busy_q;
  logic               rd_q;
  logic [DATA_W-1:0]  cap_q;
  logic               in_data;
  logic               in_release;

  assign in_data    = (32'(idx_q) >= DATA_AT);
  assign in_release = (32'(idx_q) >= TA_AT);
  assign done_o     = busy_q && fall_i && (idx_q == LAST_IDX);
  assign busy_o     = busy_q;
  assign mdio_o     = busy_q ? shift_q[SEQ_LEN-1] : 1'b1;
  assign mdio_oe_o  = busy_q && !(rd_q && in_release);
  assign rd_data_o  = cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      cap_q   <= '0;
    end else if (start_i && !busy_q) begin
      shift_q <= word_i;
      idx_q   <= '0;
      busy_q  <= 1'b1;
      rd_q    <= is_read_i;
    end else if (busy_q) begin
      if (rise_i && rd_q && in_data)
        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
        end else begin
          idx_q   <= idx_q + 1'b1;
          shift_q <= {shift_q[SEQ_LEN-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_event_reg.sv
module mdio_event_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic w1c_i,
  input  logic en_i,
  output logic event_o,
  output logic irq_o
);
  logic evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     evt_q <= 1'b0;
    else if (set_i) evt_q <= 1'b1;
    else if (w1c_i) evt_q <= 1'b0;
  end

  assign event_o = evt_q;
  assign irq_o   = evt_q && en_i;
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
  parameter int REG_W   = 32,
  parameter int DIV_W   = 6,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_wr_i,
  input  logic [REG_W-1:0] frame_wdata_i,
  output logic [REG_W-1:0] frame_rdata_o,
  input  logic             div_wr_i,
  input  logic [REG_W-1:0] div_wdata_i,
  input  logic             evt_w1c_i,
  input  logic             irq_en_i,
  output logic             event_o,
  output logic             irq_o,
  output logic             busy_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  import mdio_pkg::*;

  localparam int SEQ_LEN = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;

  logic [REG_W-1:0]   frame_q;
  logic [DIV_W-1:0]   div_q;
  logic               cmd_ok;
  logic               cmd_rd;
  logic               start;
  logic               busy;
  logic               done;
  logic               rise, fall;
  logic [DATA_W-1:0]  rd_data;
  logic [SEQ_LEN-1:0] word;
  mdio_op_e           op;

  assign cmd_rd = frame_wdata_i[CMD_RD];
  assign cmd_ok = frame_wdata_i[CMD_VLD_HI] && frame_wdata_i[CMD_VLD_LO]
                  && (frame_wdata_i[CMD_RD] ^ frame_wdata_i[CMD_WR]);
  assign start  = frame_wr_i && !busy && cmd_ok && (div_q != '0);
  assign op     = cmd_rd ? OP_READ : OP_WRITE;
  assign word   = {{PRE_LEN{1'b1}}, SOF_PATTERN, op,
                   frame_wdata_i[CMD_PHY_LSB +: ADDR_W],
                   frame_wdata_i[CMD_REG_LSB +: ADDR_W],
                   TA_DRIVEN, frame_wdata_i[DATA_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      div_q   <= '0;
    end else begin
      if (div_wr_i)
        div_q <= div_wdata_i[DIV_LSB +: DIV_W];
      if (frame_wr_i && !busy)
        frame_q <= frame_wdata_i;
      else if (done && frame_q[CMD_RD])
        frame_q[DATA_W-1:0] <= rd_data;
    end
  end

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .div_i  (div_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_seq #(.SEQ_LEN(SEQ_LEN), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .is_read_i (cmd_rd),
    .word_i    (word),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rd_data_o (rd_data)
  );

  mdio_event_reg u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (done),
    .w1c_i   (evt_w1c_i),
    .en_i    (irq_en_i),
    .event_o (event_o),
    .irq_o   (irq_o)
  );

  assign busy_o        = busy;
  assign frame_rdata_o = frame_q;
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk #(
  parameter int REG_W = 32,
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_wr_i,
  input logic [REG_W-1:0] frame_rdata_o,
  input logic [DIV_W-1:0] div_q,
  input logic             busy_o,
  input logic             mdc_o,
  input logic             mdio_o,
  input logic             mdio_oe_o,
  input logic             event_o
);
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mdc_o); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mdio_oe_o && mdio_o)); // R5
  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$fell(mdc_o)) |-> $stable(mdio_o)); // R5
  AST_DIV_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wr_i && div_q == '0 && !busy_o) |=> !busy_o); // R2
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(frame_rdata_o)); // R8
  AST_DONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> event_o); // R7
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk #(.REG_W(REG_W), .DIV_W(DIV_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_wr_i    (frame_wr_i),
  .frame_rdata_o (frame_rdata_o),
  .div_q         (div_q),
  .busy_o        (busy_o),
  .mdc_o         (mdc_o),
  .mdio_o        (mdio_o),
  .mdio_oe_o     (mdio_oe_o),
  .event_o       (event_o)
);

// File: tb/test_mdio_frame_ctrl.sv
module test_mdio_frame_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_wr = 1'b0;
  logic [31:0] frame_wdata = '0;
  logic [31:0] frame_rdata;
  logic        div_wr = 1'b0;
  logic [31:0] div_wdata = '0;
  logic        evt_w1c = 1'b0;
  logic        irq_en = 1'b0;
  logic        event_w, irq_w, busy, mdc, mdio_out, mdio_oe;
  logic        phy_drv = 1'b1;

  int checks = 0;
  int errors = 0;
  int frames_seen = 0;
  bit finished = 0;
  logic [15:0] phy_data = '0;
  logic [63:0] exp_bus_q[$];
  logic [63:0] exp_oe_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_frame_ctrl i_mdio_frame_ctrl (
    .clk(clk), .rst_n(rst_n),
    .frame_wr_i(frame_wr), .frame_wdata_i(frame_wdata), .frame_rdata_o(frame_rdata),
    .div_wr_i(div_wr), .div_wdata_i(div_wdata),
    .evt_w1c_i(evt_w1c), .irq_en_i(irq_en),
    .event_o(event_w), .irq_o(irq_w), .busy_o(busy),
    .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(phy_drv)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd(input bit rd, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    return {1'b0, 1'b1, rd, !rd, phy, rg, 1'b1, 1'b0, d};
  endfunction

  task automatic set_div(input int v);
    @(negedge clk); div_wr = 1'b1; div_wdata = 32'(v) << 1;
    @(negedge clk); div_wr = 1'b0;
  endtask

  task automatic write_frame(input logic [31:0] w);
    @(negedge clk); frame_wr = 1'b1; frame_wdata = w;
    @(negedge clk); frame_wr = 1'b0;
  endtask

  // driver: push the expected bus frame and enable pattern, then write
  task automatic issue(input logic [31:0] w, input logic [15:0] rdval);
    bit rd = w[29];
    phy_data = rdval;
    exp_bus_q.push_back({32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, w[27:23], w[22:18],
                         rd ? 2'b10 : 2'b10, rd ? rdval : w[15:0]});
    exp_oe_q.push_back(rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}});
    write_frame(w);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // PHY model and monitor: sample the line on rising MDC, drive on falling MDC
  initial begin
    int nrise = 0;
    logic [63:0] bus_w = '0, oe_w = '0;
    forever begin
      @(mdc);
      if (mdc) begin
        bus_w = {bus_w[62:0], mdio_oe ? mdio_out : phy_drv};
        oe_w  = {oe_w[62:0], mdio_oe};
        nrise++;
        if (nrise == 64) begin
          logic [63:0] eb, eo;
          nrise = 0;
          frames_seen++;
          if (exp_bus_q.size() == 0) begin
            check(0, "R8 unexpected frame", bus_w, 64'h0);
          end else begin
            eb = exp_bus_q.pop_front();
            eo = exp_oe_q.pop_front();
            check(bus_w == eb, "R4 frame bits", bus_w, eb);
            check(oe_w == eo, "R5 enable pattern", oe_w, eo);
          end
        end
      end else begin
        if (nrise == 47)                      phy_drv = 1'b0;
        else if (nrise >= 48 && nrise < 64)   phy_drv = phy_data[63 - nrise];
        else                                  phy_drv = 1'b1;
      end
    end
  end

  task automatic period_check(input int v);
    realtime t1, t2;
    @(posedge mdc); t1 = $realtime;
    @(posedge mdc); t2 = $realtime;
    check(int'((t2 - t1) / CLK_PERIOD) == 2 * (v + 1), "R3 MDC period",
          64'(int'((t2 - t1) / CLK_PERIOD)), 64'(2 * (v + 1)));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!busy && !mdc && !event_w && !irq_w && frame_rdata == 0 && !mdio_oe,
          "R9 reset state", {busy, mdc, event_w, frame_rdata}, 64'h0);

    // R2 divider zero: stored but no frame
    w = cmd(0, 5'h02, 5'h04, 16'h1234);
    write_frame(w);
    repeat (40) begin
      @(negedge clk);
      if (busy || mdc) break;
    end
    check(!busy && !mdc && !event_w, "R2 zero divider blocks start", {busy, mdc}, 64'h0);
    check(frame_rdata == w, "R1 idle write stored", frame_rdata, w);

    set_div(1);
    // R1 malformed words: bit 17 clear, and both read and write set
    w = cmd(0, 5'h02, 5'h04, 16'h1234) & ~32'h0002_0000;
    write_frame(w);
    repeat (10) @(negedge clk);
    check(!busy, "R1 missing bit 17 no start", busy, 0);
    write_frame(cmd(0, 5'h02, 5'h04, 16'h1234) | 32'h2000_0000);
    repeat (10) @(negedge clk);
    check(!busy, "R1 read and write both set no start", busy, 0);

    // write transaction, divider 1
    w = cmd(0, 5'h11, 5'h03, 16'hA5C3);
    issue(w, 16'h0000);
    check(busy, "R9 busy after accepted write", busy, 1);
    period_check(1);
    write_frame(cmd(1, 5'h07, 5'h07, 16'h0000));
    check(frame_rdata == w, "R8 write while busy ignored", frame_rdata, w);
    wait_idle();
    check(event_w && !irq_w, "R7 event set, irq masked", {event_w, irq_w}, 64'b10);
    check(frame_rdata == w, "R6 write leaves data bits", frame_rdata, w);
    @(negedge clk); irq_en = 1'b1;
    @(negedge clk);
    check(irq_w, "R7 irq when enabled", irq_w, 1);
    evt_w1c = 1'b1;
    @(negedge clk); evt_w1c = 1'b0;
    check(!event_w && !irq_w, "R7 write one clears event", {event_w, irq_w}, 0);

    // read transaction, divider 3
    set_div(3);
    w = cmd(1, 5'h01, 5'h1F, 16'h0000);
    issue(w, 16'h3C96);
    period_check(3);
    wait_idle();
    check(frame_rdata == {w[31:16], 16'h3C96}, "R6 read data returned",
          frame_rdata, {w[31:16], 16'h3C96});
    check(event_w, "R7 event after read", event_w, 1);

    // read transaction, divider 2
    set_div(2);
    w = cmd(1, 5'h1E, 5'h00, 16'hFFFF);
    issue(w, 16'h8001);
    period_check(2);
    wait_idle();
    check(frame_rdata == {w[31:16], 16'h8001}, "R6 read data second pattern",
          frame_rdata, {w[31:16], 16'h8001});

    repeat (20) @(negedge clk);
    check(frames_seen == 3 && exp_bus_q.size() == 0, "R8 no extra frames",
          64'(frames_seen), 64'd3);
    finish_run();
  end
endmodule